// File: doc/BRIEF.md
# Phase Advance Predictor

This block forecasts the RF phase difference between a ring and a shared reference at an instant that lies a programmable whole number of reference-period ticks ahead. It keeps the newest phase-difference sample from a continuous measurement stream and tracks how old that sample is. A start strobe from the synchronization-window controller arms the block. On the next reference tick it captures the newest sample, the RF frequency word and the horizon count N.

One cycle later it presents a result record. The record holds the forecast phase, the captured frequency word, the captured N and a flag that marks an outdated sample. The record stays on the result port until the consumer accepts it with a valid/ready handshake.

The block also relays phase corrections that come back from the window controller to the RF synthesis port. Each correction waits for the next reference tick and is sent on unchanged.

Phase is an unsigned fraction of a turn, PH_W bits wide. The frequency word gives the phase advance per reference period in the same units.

Top module: `phase_advance_pred`

## Requirements
- R1: After reset `busy`, `recValid` and `synthValid` are low.
- R2: A `trigIn` pulse while `busy` is low sets `busy` at the next clock edge. A `trigIn` pulse while `busy` is high has no effect and produces no extra record.
- R3: Capture happens at the first clock edge with `t0Tick` high after the trigger is accepted. The record uses the newest sample stored before that edge and the `freqIn` and `nIn` values present at that edge. Samples that arrive later do not change the record.
- R4: `recPhase` equals (captured sample + freq × N) modulo 2^PH_W, so the result wraps past a full turn. A frequency word of all ones therefore acts as −1 per period.
- R5: `recValid` rises exactly one clock edge after the capture edge. `recFreq` and `recN` carry the captured frequency and N.
- R6: While `recValid` is high and `recReady` is low, the record fields stay stable. An edge with `recValid` and `recReady` both high clears `recValid` and `busy` at that edge.
- R7: `recStale` is 1 when no sample has been stored since reset. It is also 1 when the capture edge comes more than 2×SAMPLE_CYC clock edges after the edge that stored the newest sample. Otherwise it is 0.
- R8: A value on `corrPhase` with `corrValid` high is held and appears unchanged on `synthPhase`. It appears with a one-cycle `synthValid` pulse right after the next edge with `t0Tick` high that follows the load edge. A newer correction replaces a waiting one.
- R9: With N = 0 the forecast phase equals the captured sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| t0Tick | input | 1 | One-cycle strobe on each reference-period edge |
| trigIn | input | 1 | Start strobe from the window controller |
| sampleValid | input | 1 | New phase-difference sample present |
| sampleIn | input | PH_W | Measured phase difference, fraction of a turn |
| freqIn | input | FREQ_W | Phase advance per reference period |
| nIn | input | N_W | Horizon in reference periods |
| recValid | output | 1 | Result record available |
| recReady | input | 1 | Consumer accepts the record |
| recPhase | output | PH_W | Forecast phase difference |
| recFreq | output | FREQ_W | Captured frequency word |
| recN | output | N_W | Captured horizon |
| recStale | output | 1 | Newest sample was outdated at capture |
| busy | output | 1 | A prediction is in progress or not yet accepted |
| corrValid | input | 1 | Correction value present |
| corrPhase | input | PH_W | Corrected phase from the window controller |
| synthValid | output | 1 | Correction forwarded to RF synthesis |
| synthPhase | output | PH_W | Forwarded correction value |

## Verification
The properties assume that `t0Tick` is a single-cycle strobe and that `recReady` can be held low for any time without a protocol breach. They also assume that a trigger may come at any moment, busy or not. The bench drives every input on the falling clock edge and raises `t0Tick` for one cycle only. It keeps frequency and N constant around each capture edge so that the expected record comes from the stated arithmetic alone. To test the stale cases it idles the sample stream well beyond the limit or refreshes it shortly before capture, so it never lands on the exact threshold edge.

// File: rtl/pap_pkg.sv
package pap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_CALC  = 2'd2,
    ST_OUT   = 2'd3
  } papState_t;

  typedef struct packed {
    logic capture;
    logic loadResult;
  } papCtl_t;
endpackage

// File: rtl/pap_ctrl.sv
module pap_ctrl
  import pap_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    t0Tick,
  input  logic    trigIn,
  input  logic    recReady,
  output papCtl_t ctl,
  output logic    busy,
  output logic    recValid
);
  papState_t state, stateNext;

  always_comb begin
    stateNext      = state;
    ctl.capture    = 1'b0;
    ctl.loadResult = 1'b0;
    unique case (state)
      ST_IDLE:  if (trigIn) stateNext = ST_ARMED;
      ST_ARMED: if (t0Tick) begin
        ctl.capture = 1'b1;
        stateNext   = ST_CALC;
      end
      ST_CALC: begin
        ctl.loadResult = 1'b1;
        stateNext      = ST_OUT;
      end
      ST_OUT:   if (recReady) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy     = (state != ST_IDLE);
  assign recValid = (state == ST_OUT);
endmodule

// File: rtl/pap_datapath.sv
module pap_datapath
  import pap_pkg::*;
#(
  parameter int PH_W       = 16,
  parameter int FREQ_W     = 16,
  parameter int N_W        = 12,
  parameter int SAMPLE_CYC = 403
) (
  input  logic              clk,
  input  logic              rstN,
  input  papCtl_t           ctl,
  input  logic              t0Tick,
  input  logic              sampleValid,
  input  logic [PH_W-1:0]   sampleIn,
  input  logic [FREQ_W-1:0] freqIn,
  input  logic [N_W-1:0]    nIn,
  input  logic              corrValid,
  input  logic [PH_W-1:0]   corrPhase,
  output logic [PH_W-1:0]   recPhase,
  output logic [FREQ_W-1:0] recFreq,
  output logic [N_W-1:0]    recN,
  output logic              recStale,
  output logic              synthValid,
  output logic [PH_W-1:0]   synthPhase
);
  localparam int STALE_LIM = 2 * SAMPLE_CYC;
  localparam int AGE_W     = $clog2(STALE_LIM + 1);
  localparam int PROD_W    = FREQ_W + N_W;
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(STALE_LIM);

  logic [PH_W-1:0]   lastSample;
  logic [AGE_W-1:0]  sampleAge;
  logic [PH_W-1:0]   capPhase;
  logic [FREQ_W-1:0] capFreq;
  logic [N_W-1:0]    capN;
  logic              capStale;
  logic [PROD_W-1:0] advance;
  logic [PH_W-1:0]   corrHold;
  logic              corrPending;

  // sample tracking: age saturates at the stale limit, and reset starts there
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastSample <= '0;
      sampleAge  <= AGE_MAX;
    end else if (sampleValid) begin
      lastSample <= sampleIn;
      sampleAge  <= '0;
    end else if (sampleAge != AGE_MAX) begin
      sampleAge  <= sampleAge + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capPhase <= '0;
      capFreq  <= '0;
      capN     <= '0;
      capStale <= 1'b0;
    end else if (ctl.capture) begin
      capPhase <= lastSample;
      capFreq  <= freqIn;
      capN     <= nIn;
      capStale <= (sampleAge == AGE_MAX);
    end
  end

  assign advance = {{N_W{1'b0}}, capFreq} * {{FREQ_W{1'b0}}, capN};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      recPhase <= '0;
      recFreq  <= '0;
      recN     <= '0;
      recStale <= 1'b0;
    end else if (ctl.loadResult) begin
      recPhase <= capPhase + advance[PH_W-1:0];
      recFreq  <= capFreq;
      recN     <= capN;
      recStale <= capStale;
    end
  end

  // correction relay, released on the reference tick
  always_ff @(posedge clk) begin
    if (!rstN) begin
      corrHold    <= '0;
      corrPending <= 1'b0;
      synthValid  <= 1'b0;
      synthPhase  <= '0;
    end else begin
      synthValid <= 1'b0;
      if (corrValid) begin
        corrHold    <= corrPhase;
        corrPending <= 1'b1;
      end else if (t0Tick && corrPending) begin
        corrPending <= 1'b0;
      end
      if (t0Tick && corrPending && !corrValid) begin
        synthValid <= 1'b1;
        synthPhase <= corrHold;
      end
    end
  end
endmodule

// File: rtl/phase_advance_pred.sv
module phase_advance_pred
  import pap_pkg::*;
#(
  parameter int PH_W       = 16,
  parameter int FREQ_W     = 16,
  parameter int N_W        = 12,
  parameter int SAMPLE_CYC = 403
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              t0Tick,
  input  logic              trigIn,
  input  logic              sampleValid,
  input  logic [PH_W-1:0]   sampleIn,
  input  logic [FREQ_W-1:0] freqIn,
  input  logic [N_W-1:0]    nIn,
  output logic              recValid,
  input  logic              recReady,
  output logic [PH_W-1:0]   recPhase,
  output logic [FREQ_W-1:0] recFreq,
  output logic [N_W-1:0]    recN,
  output logic              recStale,
  output logic              busy,
  input  logic              corrValid,
  input  logic [PH_W-1:0]   corrPhase,
  output logic              synthValid,
  output logic [PH_W-1:0]   synthPhase
);
  papCtl_t ctl;

  pap_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .t0Tick   (t0Tick),
    .trigIn   (trigIn),
    .recReady (recReady),
    .ctl      (ctl),
    .busy     (busy),
    .recValid (recValid)
  );

  pap_datapath #(
    .PH_W       (PH_W),
    .FREQ_W     (FREQ_W),
    .N_W        (N_W),
    .SAMPLE_CYC (SAMPLE_CYC)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .t0Tick      (t0Tick),
    .sampleValid (sampleValid),
    .sampleIn    (sampleIn),
    .freqIn      (freqIn),
    .nIn         (nIn),
    .corrValid   (corrValid),
    .corrPhase   (corrPhase),
    .recPhase    (recPhase),
    .recFreq     (recFreq),
    .recN        (recN),
    .recStale    (recStale),
    .synthValid  (synthValid),
    .synthPhase  (synthPhase)
  );
endmodule

// File: rtl/pap_chk.sv
module pap_chk #(
  parameter int PH_W   = 16,
  parameter int FREQ_W = 16,
  parameter int N_W    = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              t0Tick,
  input logic              trigIn,
  input logic              recValid,
  input logic              recReady,
  input logic [PH_W-1:0]   recPhase,
  input logic [FREQ_W-1:0] recFreq,
  input logic [N_W-1:0]    recN,
  input logic              busy,
  input logic              synthValid
);
  // R2
  idle_trigger_arms_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && trigIn) |=> busy);

  // R5
  record_implies_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    recValid |-> busy);

  // R6
  record_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (recValid && !recReady) |=> (recValid && $stable(recPhase) && $stable(recFreq) && $stable(recN)));

  // R6
  accept_releases_chk: assert property (@(posedge clk) disable iff (!rstN)
    (recValid && recReady) |=> (!recValid && !busy));

  // R8
  synth_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    synthValid |=> !synthValid);

  // R8
  synth_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(synthValid) |-> $past(t0Tick));
endmodule

bind phase_advance_pred pap_chk #(
  .PH_W   (PH_W),
  .FREQ_W (FREQ_W),
  .N_W    (N_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .t0Tick     (t0Tick),
  .trigIn     (trigIn),
  .recValid   (recValid),
  .recReady   (recReady),
  .recPhase   (recPhase),
  .recFreq    (recFreq),
  .recN       (recN),
  .busy       (busy),
  .synthValid (synthValid)
);

// File: tb/phase_advance_pred_bench.sv
module phase_advance_pred_bench;
  localparam int PH_W = 16, FREQ_W = 16, N_W = 12, SAMPLE_CYC = 403;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic t0Tick = 0, trigIn = 0, sampleValid = 0, recReady = 0, corrValid = 0;
  logic [PH_W-1:0] sampleIn = '0, corrPhase = '0;
  logic [FREQ_W-1:0] freqIn = '0;
  logic [N_W-1:0] nIn = '0;
  logic recValid, recStale, busy, synthValid;
  logic [PH_W-1:0] recPhase, synthPhase;
  logic [FREQ_W-1:0] recFreq;
  logic [N_W-1:0] recN;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  phase_advance_pred #(.PH_W(PH_W), .FREQ_W(FREQ_W), .N_W(N_W), .SAMPLE_CYC(SAMPLE_CYC))
    u_phase_advance_pred (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic putSample(input logic [PH_W-1:0] v);
    sampleValid = 1; sampleIn = v; @(negedge clk); sampleValid = 0;
  endtask

  // trigger, wait, tick; returns at the negedge right after the capture edge
  task automatic runCapture(input logic [FREQ_W-1:0] f, input logic [N_W-1:0] n);
    freqIn = f; nIn = n;
    trigIn = 1; @(negedge clk); trigIn = 0;
    idle(2);
    t0Tick = 1; @(negedge clk); t0Tick = 0;
  endtask

  task automatic expectRecord(input string req, input logic [PH_W-1:0] ph,
                              input logic [FREQ_W-1:0] f, input logic [N_W-1:0] n,
                              input logic st);
    check({req, " not yet valid"}, recValid, 0);
    @(negedge clk);
    check({req, " valid"}, recValid, 1);
    check({req, " phase"}, recPhase, ph);
    check({req, " freq R5"}, recFreq, f);
    check({req, " n R5"}, recN, n);
    check({req, " stale R7"}, recStale, st);
  endtask

  task automatic accept();
    recReady = 1; @(negedge clk); recReady = 0;
  endtask

  task automatic testReset();
    check("R1 busy", busy, 0);
    check("R1 recValid", recValid, 0);
    check("R1 synthValid", synthValid, 0);
  endtask

  task automatic testNoSampleStale();
    runCapture(16'h0010, 12'd3);
    expectRecord("R7 none since reset", 16'h0030, 16'h0010, 12'd3, 1);
    accept();
  endtask

  task automatic testBasic();
    putSample(16'h1234);
    idle(3);
    trigIn = 1; freqIn = 16'h0100; nIn = 12'd5; @(negedge clk); trigIn = 0;
    check("R2 busy after trigger", busy, 1);
    putSample(16'h1234);
    t0Tick = 1; @(negedge clk); t0Tick = 0;
    freqIn = 16'hAAAA; nIn = 12'd77;
    putSample(16'h5555); // after capture, must not matter (R3)
    check("R3 late sample ignored, valid", recValid, 1);
    check("R3 R4 phase", recPhase, 16'h1734);
    check("R5 freq", recFreq, 16'h0100);
    check("R5 n", recN, 12'd5);
    check("R7 fresh", recStale, 0);
    idle(3);
    check("R6 held valid", recValid, 1);
    check("R6 held phase", recPhase, 16'h1734);
    accept();
    check("R6 released valid", recValid, 0);
    check("R6 released busy", busy, 0);
  endtask

  task automatic testWrap();
    putSample(16'hF000);
    runCapture(16'h0300, 12'h010);
    expectRecord("R4 wrap", 16'h2000, 16'h0300, 12'h010, 0);
    accept();
    putSample(16'h0001);
    runCapture(16'hFFFF, 12'd2);
    expectRecord("R4 negative", 16'hFFFF, 16'hFFFF, 12'd2, 0);
    accept();
  endtask

  task automatic testZeroN();
    putSample(16'h4321);
    runCapture(16'h7777, 12'd0);
    expectRecord("R9", 16'h4321, 16'h7777, 12'd0, 0);
    accept();
  endtask

  task automatic testBusyTrigger();
    putSample(16'h0100);
    runCapture(16'h0001, 12'd1);
    expectRecord("R2 first", 16'h0101, 16'h0001, 12'd1, 0);
    trigIn = 1; @(negedge clk); trigIn = 0;
    accept();
    for (int i = 0; i < 3; i++) begin
      t0Tick = 1; @(negedge clk); t0Tick = 0;
      idle(1);
    end
    check("R2 busy trigger ignored, busy", busy, 0);
    check("R2 busy trigger ignored, record", recValid, 0);
  endtask

  task automatic testStaleAge();
    putSample(16'h0200);
    idle(2 * SAMPLE_CYC + 100);
    runCapture(16'h0001, 12'd4);
    expectRecord("R7 aged out", 16'h0204, 16'h0001, 12'd4, 1);
    accept();
  endtask

  task automatic testCorrection();
    corrValid = 1; corrPhase = 16'hBEEF; @(negedge clk); corrValid = 0;
    idle(2);
    check("R8 waits for tick", synthValid, 0);
    t0Tick = 1; @(negedge clk); t0Tick = 0;
    check("R8 pulse", synthValid, 1);
    check("R8 value", synthPhase, 16'hBEEF);
    @(negedge clk);
    check("R8 one cycle", synthValid, 0);
    corrValid = 1; corrPhase = 16'h1111; @(negedge clk);
    corrPhase = 16'h2222; @(negedge clk); corrValid = 0;
    t0Tick = 1; @(negedge clk); t0Tick = 0;
    check("R8 newest value", synthPhase, 16'h2222);
    check("R8 newest pulse", synthValid, 1);
  endtask

  initial begin
    idle(3);
    testReset();
    rstN = 1;
    idle(2);
    testNoSampleStale();
    testBasic();
    testWrap();
    testZeroN();
    testBusyTrigger();
    testStaleAge();
    testCorrection();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule